// File: doc/BRIEF.md
# Serial Configuration Register Slave

This block is a two-wire serial slave running at the standard 100 kbit/s bus rate. It owns a small bank of 8-bit configuration registers and drives each register bit onto the parallel output bus, so the rest of the chip can read them at any time. A master changes the bank only through block transfers. Each write begins with two header bytes, a command byte and a byte-count byte. The slave acknowledges both and then throws their values away. Every data byte after that lands in the next register, starting at register 0.

A read returns a byte count first and then the registers from register 0 upward. The read continues until the master declines a byte. The serial lines are synchronized into the system clock domain. START and STOP are recognised as SDA edges while SCL is high. The slave pulls SDA low through an open-drain enable and never stretches the clock. The system clock must run several times faster than SCL so that each SCL phase spans enough synchronized samples.

Top module: `i2c_cfg_bank`

## Requirements
- R1: After reset, register 0 holds 0x00 and registers 1 to 6 hold 0xFF. Register k appears on `cfgRegs[8k+7:8k]`.
- R2: The slave acknowledges the address byte 0xD2 (write) and 0xD3 (read). It does not acknowledge any other address byte, and bytes that follow a foreign address leave every register unchanged.
- R3: In a write, the slave acknowledges the first two bytes after the address and discards them. Each later byte loads the next register, starting at register 0. Bytes travel MSB first.
- R4: A STOP after any acknowledged data byte keeps the bytes already written. Registers that the transfer did not reach keep their values.
- R5: In a write, the slave acknowledges data bytes beyond register 6 and discards them.
- R6: A read returns the byte 0x07 first and then registers 0, 1, 2 and onward, MSB first, one byte for each master acknowledge.
- R7: After the master answers a read byte with NACK, the slave releases SDA. Further SCL pulses read as all ones until the next START or STOP.
- R8: A byte that a STOP or repeated START interrupts before its eighth bit is not stored.
- R9: Every START, including a repeated START, resets the register position, so the next transfer begins at register 0.
- R10: The slave changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Serial clock line as seen at the pad |
| sdaIn | input | 1 | Serial data line as seen at the pad |
| sdaOe | output | 1 | Open-drain enable: 1 pulls SDA low |
| cfgRegs | output | NUM_REGS*8 | Register bank; register k at bits 8k+7:8k |

## Verification
Two events can fall on the same SCL high phase: a bus condition (STOP or repeated START) and a byte that is partway through being shifted in. A correct slave lets the bus condition win and drops the partial byte. The bench provokes this by sending a complete data byte, then only a few bits of the next one, and then either a STOP or a repeated START followed by a read. It then checks that the parallel bus, and the value read back at register 0, hold the last complete byte and no trace of the cut-off bits.

// File: rtl/i2c_cfg_pkg.sv
package i2c_cfg_pkg;

  typedef struct packed {
    logic ptrClear;
    logic wrCommit;
    logic txLoadCount;
    logic txLoadReg;
    logic txShift;
  } dpStrobe_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR_BYTE,
    ST_WR_ACK,
    ST_RD_BYTE,
    ST_RD_ACK,
    ST_WAIT
  } busState_t;

endpackage

// File: rtl/i2c_cfg_ctrl.sv
module i2c_cfg_ctrl
  import i2c_cfg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR   = 7'h69,
  parameter int         HDR_BYTES  = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  output dpStrobe_t  strobe,
  output logic [7:0] rxByte,
  output logic       ackDrive,
  output logic       txDrive
);

  localparam int HDR_W = $clog2(HDR_BYTES + 1);

  logic [1:0] sclPipe, sdaPipe;
  logic       sclPrev, sdaPrev;
  logic       sclS, sdaS;
  logic       sclRise, sclFall, startDet, stopDet;

  busState_t        state, stateN;
  logic [2:0]       bitCnt, bitCntN;
  logic             byteDone, byteDoneN;
  logic [7:0]       shReg, shN;
  logic             isRead, isReadN;
  logic [HDR_W-1:0] hdrCnt, hdrN;
  logic             mstAck, mstAckN;
  logic             ackN, txN;

  // Two-flop synchronizers plus one history flop for edge detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= 2'b11;
      sdaPipe <= 2'b11;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[0], sclIn};
      sdaPipe <= {sdaPipe[0], sdaIn};
      sclPrev <= sclPipe[1];
      sdaPrev <= sdaPipe[1];
    end
  end

  assign sclS     = sclPipe[1];
  assign sdaS     = sdaPipe[1];
  assign sclRise  = sclS & ~sclPrev;
  assign sclFall  = ~sclS & sclPrev;
  assign startDet = sclS & sclPrev & sdaPrev & ~sdaS;
  assign stopDet  = sclS & sclPrev & ~sdaPrev & sdaS;
  assign rxByte   = shReg;

  always_comb begin
    stateN    = state;
    bitCntN   = bitCnt;
    byteDoneN = byteDone;
    shN       = shReg;
    isReadN   = isRead;
    hdrN      = hdrCnt;
    mstAckN   = mstAck;
    ackN      = ackDrive;
    txN       = txDrive;
    strobe    = '0;
    if (stopDet) begin
      stateN = ST_IDLE;
      ackN   = 1'b0;
      txN    = 1'b0;
    end else if (startDet) begin
      stateN          = ST_ADDR;
      bitCntN         = '0;
      byteDoneN       = 1'b0;
      ackN            = 1'b0;
      txN             = 1'b0;
      strobe.ptrClear = 1'b1;
    end else begin
      case (state)
        ST_ADDR, ST_WR_BYTE: begin
          if (sclRise && !byteDone) begin
            shN     = {shReg[6:0], sdaS};
            bitCntN = bitCnt + 3'd1;
            if (bitCnt == 3'd7) byteDoneN = 1'b1;
          end else if (sclFall && byteDone) begin
            byteDoneN = 1'b0;
            bitCntN   = '0;
            if (state == ST_ADDR) begin
              if (shReg[7:1] == DEV_ADDR) begin
                ackN    = 1'b1;
                isReadN = shReg[0];
                hdrN    = '0;
                stateN  = ST_ADDR_ACK;
              end else begin
                stateN = ST_WAIT;
              end
            end else begin
              ackN   = 1'b1;
              stateN = ST_WR_ACK;
              if (hdrCnt == HDR_W'(HDR_BYTES)) strobe.wrCommit = 1'b1;
              else hdrN = hdrCnt + 1'b1;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (sclFall) begin
            ackN = 1'b0;
            if (isRead) begin
              strobe.txLoadCount = 1'b1;
              txN                = 1'b1;
              stateN             = ST_RD_BYTE;
            end else begin
              stateN = ST_WR_BYTE;
            end
          end
        end
        ST_WR_ACK: begin
          if (sclFall) begin
            ackN   = 1'b0;
            stateN = ST_WR_BYTE;
          end
        end
        ST_RD_BYTE: begin
          if (sclRise) begin
            bitCntN = bitCnt + 3'd1;
            if (bitCnt == 3'd7) byteDoneN = 1'b1;
          end else if (sclFall) begin
            if (byteDone) begin
              byteDoneN = 1'b0;
              bitCntN   = '0;
              txN       = 1'b0;
              stateN    = ST_RD_ACK;
            end else begin
              strobe.txShift = 1'b1;
            end
          end
        end
        ST_RD_ACK: begin
          if (sclRise) begin
            mstAckN = ~sdaS;
          end else if (sclFall) begin
            if (mstAck) begin
              strobe.txLoadReg = 1'b1;
              txN              = 1'b1;
              stateN           = ST_RD_BYTE;
            end else begin
              stateN = ST_WAIT;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      bitCnt   <= '0;
      byteDone <= 1'b0;
      shReg    <= '0;
      isRead   <= 1'b0;
      hdrCnt   <= '0;
      mstAck   <= 1'b0;
      ackDrive <= 1'b0;
      txDrive  <= 1'b0;
    end else begin
      state    <= stateN;
      bitCnt   <= bitCntN;
      byteDone <= byteDoneN;
      shReg    <= shN;
      isRead   <= isReadN;
      hdrCnt   <= hdrN;
      mstAck   <= mstAckN;
      ackDrive <= ackN;
      txDrive  <= txN;
    end
  end

  // R10: the acknowledge drive begins only while SCL is low
  assert_ack_scl_low_R10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ackDrive) |-> !sclS);

  // R10: the data drive begins only while SCL is low
  assert_tx_scl_low_R10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txDrive) |-> !sclS);

  // R7: while the slave waits for a bus condition, it drives nothing
  assert_wait_quiet_R7: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT) |-> (!ackDrive && !txDrive));

  // R2: the slave never acknowledges and sends data at once
  assert_no_dual_drive_R2: assert property (@(posedge clk) disable iff (!rstN)
    !(ackDrive && txDrive));

endmodule

// File: rtl/i2c_cfg_dp.sv
module i2c_cfg_dp
  import i2c_cfg_pkg::*;
#(
  parameter int NUM_REGS = 7,
  parameter int DATA_W   = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  dpStrobe_t                  strobe,
  input  logic [DATA_W-1:0]          rxByte,
  output logic                       txBit,
  output logic [NUM_REGS*DATA_W-1:0] cfgRegs
);

  localparam int PTR_W = $clog2(NUM_REGS + 1);
  localparam logic [PTR_W-1:0] PTR_END = PTR_W'(NUM_REGS);

  logic [NUM_REGS-1:0][DATA_W-1:0] regBank;
  logic [PTR_W-1:0]                ptr;
  logic [DATA_W-1:0]               txSh, rdVal;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_REGS; i++)
        regBank[i] <= (i == 0) ? '0 : '1;
    end else if (strobe.wrCommit) begin
      for (int i = 0; i < NUM_REGS; i++)
        if (ptr == PTR_W'(i)) regBank[i] <= rxByte;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ptr <= '0;
    else if (strobe.ptrClear) ptr <= '0;
    else if ((strobe.wrCommit || strobe.txLoadReg) && ptr != PTR_END) ptr <= ptr + 1'b1;
  end

  always_comb begin
    rdVal = '1;
    for (int i = 0; i < NUM_REGS; i++)
      if (ptr == PTR_W'(i)) rdVal = regBank[i];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) txSh <= '1;
    else if (strobe.txLoadCount) txSh <= DATA_W'(NUM_REGS);
    else if (strobe.txLoadReg) txSh <= rdVal;
    else if (strobe.txShift) txSh <= {txSh[DATA_W-2:0], 1'b1};
  end

  assign txBit   = txSh[DATA_W-1];
  assign cfgRegs = regBank;

  // R4: registers change only on a committed data byte
  assert_regs_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.wrCommit |=> $stable(regBank));

  // R9: a START returns the position to register 0
  assert_ptr_clear_R9: assert property (@(posedge clk) disable iff (!rstN)
    strobe.ptrClear |=> (ptr == '0));

  // R6: a read opens with the register count
  assert_count_first_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.txLoadCount |=> (txSh == DATA_W'(NUM_REGS)));

endmodule

// File: rtl/i2c_cfg_bank.sv
module i2c_cfg_bank
  import i2c_cfg_pkg::*;
#(
  parameter int         NUM_REGS = 7,
  parameter logic [6:0] DEV_ADDR = 7'h69
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  sclIn,
  input  logic                  sdaIn,
  output logic                  sdaOe,
  output logic [NUM_REGS*8-1:0] cfgRegs
);

  dpStrobe_t  strobe;
  logic [7:0] rxByte;
  logic       ackDrive, txDrive, txBit;

  i2c_cfg_ctrl #(.DEV_ADDR(DEV_ADDR), .HDR_BYTES(2)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .sclIn    (sclIn),
    .sdaIn    (sdaIn),
    .strobe   (strobe),
    .rxByte   (rxByte),
    .ackDrive (ackDrive),
    .txDrive  (txDrive)
  );

  i2c_cfg_dp #(.NUM_REGS(NUM_REGS), .DATA_W(8)) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .rxByte  (rxByte),
    .txBit   (txBit),
    .cfgRegs (cfgRegs)
  );

  assign sdaOe = ackDrive | (txDrive & ~txBit);

endmodule

// File: tb/sim_i2c_cfg_bank.sv
module sim_i2c_cfg_bank;

  localparam int HP = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sclM = 1'b1;
  logic        sdaM = 1'b1;
  logic        sdaOe;
  logic [55:0] cfgRegs;
  wire         sdaLine = sdaM & ~sdaOe;

  int          checks = 0;
  int          errors = 0;
  logic [7:0]  model [7];
  logic [7:0]  expQ [$];
  logic [7:0]  obsByte;
  event        rdEvt;
  int          r10Viol = 0;
  logic        sclMPrev = 1'b1;
  logic        oePrev = 1'b0;

  always #5 clk = ~clk;

  i2c_cfg_bank u0 (
    .clk     (clk),
    .rstN    (rstN),
    .sclIn   (sclM),
    .sdaIn   (sdaLine),
    .sdaOe   (sdaOe),
    .cfgRegs (cfgRegs)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chkRegs(input string tag);
    logic [55:0] e;
    for (int i = 0; i < 7; i++) e[i*8 +: 8] = model[i];
    chk(tag, {8'h00, cfgRegs}, {8'h00, e});
  endtask

  // Scoreboard monitor: compares each read byte with the queued expectation
  always @(rdEvt) begin
    if (expQ.size() == 0) chk("R6 unexpected byte", {56'h0, obsByte}, 64'hx);
    else chk("R6 read byte", {56'h0, obsByte}, {56'h0, expQ.pop_front()});
  end

  // R10 monitor: slave drive must not change during an SCL high phase
  always @(posedge clk) begin
    if (rstN && sclM && sclMPrev && (sdaOe !== oePrev)) r10Viol++;
    sclMPrev <= sclM;
    oePrev   <= sdaOe;
  end

  task automatic waitHp();
    repeat (HP) @(negedge clk);
  endtask

  task automatic busStart();
    sdaM = 1'b1; waitHp();
    sclM = 1'b1; waitHp();
    sdaM = 1'b0; waitHp();
    sclM = 1'b0; waitHp();
  endtask

  task automatic busStop();
    sdaM = 1'b0; waitHp();
    sclM = 1'b1; waitHp();
    sdaM = 1'b1; waitHp();
  endtask

  task automatic sendBit(input logic b, output logic seen);
    sdaM = b; waitHp();
    sclM = 1'b1; waitHp();
    seen = sdaLine;
    sclM = 1'b0; waitHp();
  endtask

  task automatic writeByte(input logic [7:0] d, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) sendBit(d[i], s);
    sendBit(1'b1, s);
    ack = ~s;
  endtask

  task automatic readRaw(input logic mAck, output logic [7:0] v);
    logic s;
    for (int i = 0; i < 8; i++) begin
      sendBit(1'b1, s);
      v = {v[6:0], s};
    end
    sendBit(~mAck, s);
  endtask

  task automatic readByte(input logic mAck);
    logic [7:0] v;
    readRaw(mAck, v);
    obsByte = v;
    -> rdEvt;
    @(negedge clk);
  endtask

  task automatic finishRun();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finishRun();
  end

  initial begin
    logic a;
    logic [7:0] v;
    model[0] = 8'h00;
    for (int i = 1; i < 7; i++) model[i] = 8'hFF;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (5) @(negedge clk);

    // R1: reset values on the parallel bus
    chkRegs("R1 reset values");

    // R2 R3: write with two discarded header bytes, then three data bytes
    busStart();
    writeByte(8'hD2, a); chk("R2 write address ack", {63'h0, a}, 64'h1);
    writeByte(8'hAA, a); chk("R3 command ack", {63'h0, a}, 64'h1);
    writeByte(8'h55, a); chk("R3 count ack", {63'h0, a}, 64'h1);
    writeByte(8'h11, a); chk("R3 data ack", {63'h0, a}, 64'h1);
    writeByte(8'h22, a);
    writeByte(8'h33, a);
    busStop();
    model[0] = 8'h11; model[1] = 8'h22; model[2] = 8'h33;
    chkRegs("R3 R4 registers after short write");

    // R6: read count then all registers; R7 NACK releases the line
    busStart();
    writeByte(8'hD3, a); chk("R2 read address ack", {63'h0, a}, 64'h1);
    expQ.push_back(8'h07);
    for (int i = 0; i < 7; i++) expQ.push_back(model[i]);
    for (int i = 0; i < 7; i++) readByte(1'b1);
    readByte(1'b0);
    chk("R6 queue drained", {32'h0, expQ.size()}, 64'h0);
    readRaw(1'b0, v);
    chk("R7 released after NACK", {56'h0, v}, 64'hFF);
    busStop();

    // R2: foreign address is not acknowledged and changes nothing
    busStart();
    writeByte(8'hA0, a); chk("R2 foreign address nack", {63'h0, a}, 64'h0);
    writeByte(8'h00, a);
    writeByte(8'h00, a);
    writeByte(8'h00, a);
    busStop();
    chkRegs("R2 registers untouched");

    // R5: ten data bytes, the last three discarded but acknowledged
    busStart();
    writeByte(8'hD2, a);
    writeByte(8'h00, a);
    writeByte(8'h00, a);
    for (int i = 0; i < 10; i++) begin
      writeByte(8'h40 + 8'(i), a);
      if (i >= 7) chk("R5 overflow byte ack", {63'h0, a}, 64'h1);
      if (i < 7) model[i] = 8'h40 + 8'(i);
    end
    busStop();
    chkRegs("R5 overflow discarded");

    // R8: byte cut off by STOP is dropped
    busStart();
    writeByte(8'hD2, a);
    writeByte(8'h00, a);
    writeByte(8'h00, a);
    writeByte(8'h5A, a);
    sendBit(1'b0, a); sendBit(1'b0, a); sendBit(1'b0, a); sendBit(1'b0, a);
    busStop();
    model[0] = 8'h5A;
    chkRegs("R8 partial byte before STOP dropped");

    // R8 R9: partial byte cut by repeated START, then read from register 0
    busStart();
    writeByte(8'hD2, a);
    writeByte(8'h00, a);
    writeByte(8'h00, a);
    sendBit(1'b0, a); sendBit(1'b0, a); sendBit(1'b0, a);
    busStart();
    writeByte(8'hD3, a);
    expQ.push_back(8'h07);
    expQ.push_back(model[0]);
    readByte(1'b1);
    readByte(1'b0);
    busStop();
    chkRegs("R8 partial byte before repeated START dropped");

    // R9: repeated START between two writes restarts at register 0
    busStart();
    writeByte(8'hD2, a);
    writeByte(8'h00, a);
    writeByte(8'h00, a);
    writeByte(8'h01, a);
    busStart();
    writeByte(8'hD2, a);
    writeByte(8'h00, a);
    writeByte(8'h00, a);
    writeByte(8'h02, a);
    busStop();
    model[0] = 8'h02;
    chkRegs("R9 position reset by repeated START");

    chk("R10 drive stable while SCL high", {32'h0, r10Viol}, 64'h0);
    repeat (20) @(negedge clk);
    finishRun();
  end

endmodule